// File: doc/BRIEF.md
# DMA Channel Block-Length Controller

This block holds the block-length bookkeeping for a four-channel DMA engine. Each channel keeps a live count of the transfers left in the active block and a second, separately programmed length for the block that follows. When the live count runs out, the channel either loads the waiting length and carries on, or stops and raises a terminal-count flag. All channel registers sit on one register bus. Each channel decodes its own four-register window. The enables of all channels are ORed into a shared clock-enable for the DMA datapath.

Address generation, arbitration and memory ports are outside this block. A peripheral request input per channel and a transfer-done strobe per channel stand in for them. The block answers with a transfer-request output and a width output that selects one or two bytes per transfer.

Each channel runs a four-state machine:
- `ST_IDLE`: the channel is disabled.
- `ST_ACTIVE`: the channel is counting.
- `ST_RELOAD`: a one-cycle load of the waiting length.
- `ST_HALT`: the block has ended with no valid next length.

The transitions are:
- IDLE→ACTIVE when the enable bit is 1.
- ACTIVE→IDLE when the enable is cleared.
- ACTIVE→RELOAD on the last transfer while the next length is valid.
- ACTIVE→HALT on the last transfer without a valid next length.
- RELOAD→ACTIVE, or RELOAD→IDLE if the enable is clear.
- HALT→ACTIVE when software writes the live count.
- HALT→IDLE when the enable is cleared.

Top module: `dmabl_top`

## Requirements
- R1: After reset, every register reads 0, and `xfer_req`, `irq` and `dma_clk_en` are all 0.
- R2: In ACTIVE, each `xfer_done` pulse lowers the live count (register 0) by one, unless the count is 1.
- R3: A live count of 0, whether written or reloaded, stands for 2^CNT_W transfers. One done from 0 leaves all ones.
- R4: Any write to the next-length register (register 1) sets status bit 0, the next-valid bit.
- R5: A done at count 1 with next-valid set moves the channel to RELOAD. In RELOAD `xfer_req` is 0. One cycle later the count equals the next length and next-valid is 0.
- R6: A done at count 1 with next-valid clear sets status bit 1, the terminal-count flag, and halts the channel with `xfer_req` 0. A write to the live count while halted resumes counting.
- R7: The terminal-count flag stays set until a write of 1 to status bit 1. While the flag is set and control bit 3 is 1, `irq` is 1.
- R8: A write to the next-length register while next-valid is 1 sets status bit 2, the overrun flag. Writing 1 to status bit 2 clears it. While the overrun flag is set and control bit 4 is 1, `irq` is 1.
- R9: While control bit 0 (enable) is 0, done pulses are ignored. Clearing the enable mid-block freezes the live count.
- R10: `dma_clk_en` is 1 exactly when at least one channel has its enable bit set.
- R11: In ACTIVE, `xfer_req` is (peripheral request OR control bit 2, the software request). `xfer_wide` follows control bit 1 (1 = two bytes per transfer).
- R12: `bus_addr[3:2]` selects the channel and `bus_addr[1:0]` selects its register (0 live count, 1 next length, 2 control, 3 status). An access to one channel leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Channel (upper 2 bits) and register (lower 2 bits) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| periph_req | input | 4 | Per-channel peripheral request |
| xfer_done | input | 4 | Per-channel transfer-complete strobe |
| xfer_req | output | 4 | Per-channel transfer request |
| xfer_wide | output | 4 | Per-channel two-byte transfer select |
| irq | output | 4 | Per-channel interrupt |
| dma_clk_en | output | 1 | Shared DMA clock-enable |

## Verification
The assertions check the following on every cycle:
- a request never appears on a disabled channel or while the shared clock-enable is low;
- a next-length write always leaves next-valid set, and sets the overrun flag if next-valid was already set;
- the terminal-count flag only falls after a write-one-to-clear;
- an interrupt always has a flag behind it.

Only the bench scenarios can show the following:
- the exact count sequence;
- the one-cycle request gap during reload;
- the zero-means-maximum wrap;
- the resume out of halt;
- that done pulses on a disabled channel leave the count unchanged;
- that the channel windows are kept apart.

// File: rtl/dmabl_pkg.sv
package dmabl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_RELOAD = 2'd2,
        ST_HALT   = 2'd3
    } chan_state_t;

    // register index inside a channel window
    localparam logic [1:0] RG_CUR  = 2'd0;
    localparam logic [1:0] RG_NXT  = 2'd1;
    localparam logic [1:0] RG_CTRL = 2'd2;
    localparam logic [1:0] RG_STAT = 2'd3;

    // control bit positions
    localparam int CB_EN    = 0;
    localparam int CB_WIDE  = 1;
    localparam int CB_SWREQ = 2;
    localparam int CB_TCIE  = 3;
    localparam int CB_OVIE  = 4;
    localparam int CTRL_W   = 5;

    // status bit positions
    localparam int SB_NVLD  = 0;
    localparam int SB_TC    = 1;
    localparam int SB_OVR   = 2;
    localparam int STAT_W   = 3;

endpackage

// File: rtl/dmabl_fsm.sv
module dmabl_fsm
    import dmabl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        done,
    input  logic        last,
    input  logic        nvalid,
    input  logic        cur_wr,
    output chan_state_t state,
    output logic        dec,
    output logic        ld_next,
    output logic        set_tc,
    output logic        active
);

    chan_state_t nxt_state;

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:   if (en) nxt_state = ST_ACTIVE;
            ST_ACTIVE: begin
                if (!en)
                    nxt_state = ST_IDLE;
                else if (done && last)
                    nxt_state = nvalid ? ST_RELOAD : ST_HALT;
            end
            ST_RELOAD: nxt_state = en ? ST_ACTIVE : ST_IDLE;
            ST_HALT: begin
                if (!en)
                    nxt_state = ST_IDLE;
                else if (cur_wr)
                    nxt_state = ST_ACTIVE;
            end
            default:   nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    always_comb begin
        active  = (state == ST_ACTIVE);
        dec     = active && en && done && !last;
        set_tc  = active && en && done && last && !nvalid;
        ld_next = (state == ST_RELOAD);
    end

endmodule

// File: rtl/dmabl_channel.sv
module dmabl_channel
    import dmabl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [1:0]       rsel,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic             periph_req,
    input  logic             done,
    output logic             req,
    output logic             wide,
    output logic             irq,
    output logic             en,
    output logic             tc,
    output logic             ovr,
    output logic             nvld
);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  nxt_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              cur_wr, nxt_wr, ctrl_wr, stat_wr;
    logic              dec, ld_next, set_tc, active, last;
    chan_state_t       state;

    assign cur_wr  = sel && wr && (rsel == RG_CUR);
    assign nxt_wr  = sel && wr && (rsel == RG_NXT);
    assign ctrl_wr = sel && wr && (rsel == RG_CTRL);
    assign stat_wr = sel && wr && (rsel == RG_STAT);
    assign en      = ctrl_q[CB_EN];
    assign last    = (cnt_q == CNT_W'(1));

    dmabl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .done    (done),
        .last    (last),
        .nvalid  (nvld),
        .cur_wr  (cur_wr),
        .state   (state),
        .dec     (dec),
        .ld_next (ld_next),
        .set_tc  (set_tc),
        .active  (active)
    );

    // live counter: software write beats reload, reload beats decrement
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cur_wr)  cnt_q <= wdata;
        else if (ld_next) cnt_q <= nxt_q;
        else if (dec)     cnt_q <= cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      nxt_q <= '0;
        else if (nxt_wr) nxt_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wdata[CTRL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nvld <= 1'b0;
            tc   <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (nxt_wr)       nvld <= 1'b1;
            else if (ld_next) nvld <= 1'b0;

            if (set_tc)                       tc <= 1'b1;
            else if (stat_wr && wdata[SB_TC]) tc <= 1'b0;

            if (nxt_wr && nvld)                ovr <= 1'b1;
            else if (stat_wr && wdata[SB_OVR]) ovr <= 1'b0;
        end
    end

    always_comb begin
        req  = active && en && (periph_req || ctrl_q[CB_SWREQ]);
        wide = ctrl_q[CB_WIDE];
        irq  = (tc && ctrl_q[CB_TCIE]) || (ovr && ctrl_q[CB_OVIE]);
    end

    always_comb begin
        unique case (rsel)
            RG_CUR:  rdata = cnt_q;
            RG_NXT:  rdata = nxt_q;
            RG_CTRL: rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
            RG_STAT: rdata = {{(CNT_W-STAT_W){1'b0}}, ovr, tc, nvld};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmabl_top.sv
module dmabl_top
    import dmabl_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW   = CH_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [NCH-1:0]   periph_req,
    input  logic [NCH-1:0]   xfer_done,
    output logic [NCH-1:0]   xfer_req,
    output logic [NCH-1:0]   xfer_wide,
    output logic [NCH-1:0]   irq,
    output logic             dma_clk_en
);

    logic [CNT_W-1:0] ch_rd [NCH];
    logic [NCH-1:0]   en_vec, tc_vec, ovr_vec, nvld_vec;
    logic [CH_W-1:0]  ch_idx;

    assign ch_idx = bus_addr[AW-1:2];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmabl_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (ch_idx == CH_W'(g)),
            .wr         (bus_wr),
            .rsel       (bus_addr[1:0]),
            .wdata      (bus_wdata),
            .rdata      (ch_rd[g]),
            .periph_req (periph_req[g]),
            .done       (xfer_done[g]),
            .req        (xfer_req[g]),
            .wide       (xfer_wide[g]),
            .irq        (irq[g]),
            .en         (en_vec[g]),
            .tc         (tc_vec[g]),
            .ovr        (ovr_vec[g]),
            .nvld       (nvld_vec[g])
        );
    end

    assign bus_rdata  = ch_rd[ch_idx];
    assign dma_clk_en = |en_vec;

endmodule

// File: rtl/dmabl_checker.sv
module dmabl_checker #(
    parameter int NCH = 4,
    parameter int AW  = 4,
    parameter int DW  = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [NCH-1:0] xfer_req,
    input logic [NCH-1:0] irq,
    input logic          dma_clk_en,
    input logic [NCH-1:0] en_vec,
    input logic [NCH-1:0] tc_vec,
    input logic [NCH-1:0] ovr_vec,
    input logic [NCH-1:0] nvld_vec
);

    AST_GATED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_clk_en |-> (xfer_req == '0)); // R10

    for (genvar i = 0; i < NCH; i++) begin : g_a
        AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_req[i] |-> en_vec[i]); // R9
        AST_NXT_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == AW'(i*4+1)) |=> nvld_vec[i]); // R4
        AST_OVR_ON_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == AW'(i*4+1) && nvld_vec[i]) |=> ovr_vec[i]); // R8
        AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(tc_vec[i]) |-> $past(bus_wr && bus_addr == AW'(i*4+3) && bus_wdata[1])); // R7
        AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (tc_vec[i] || ovr_vec[i])); // R7
    end

endmodule

bind dmabl_top dmabl_checker #(.NCH(NCH), .AW(AW), .DW(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .xfer_req   (xfer_req),
    .irq        (irq),
    .dma_clk_en (dma_clk_en),
    .en_vec     (en_vec),
    .tc_vec     (tc_vec),
    .ovr_vec    (ovr_vec),
    .nvld_vec   (nvld_vec)
);

// File: tb/tb_dmabl_top.sv
module tb_dmabl_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  periph_req = '0;
    logic [3:0]  xfer_done = '0;
    logic [3:0]  xfer_req, xfer_wide, irq;
    logic        dma_clk_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dmabl_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_req(periph_req),
        .xfer_done(xfer_done), .xfer_req(xfer_req), .xfer_wide(xfer_wide),
        .irq(irq), .dma_clk_en(dma_clk_en)
    );

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    event rd_go;

    // monitor: pops an expected read value and compares it with the bus
    initial begin
        forever begin
            @(rd_go);
            #2;
            if (sbq.size() != 0) begin
                exp_t it;
                it = sbq.pop_front();
                checks++;
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s rdata actual=%h expected=%h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        exp_t it;
        @(negedge clk);
        bus_addr = a;
        it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        ->rd_go;
        @(posedge clk);
    endtask

    task automatic dn(input int c, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            xfer_done[c] = 1'b1;
            @(negedge clk);
            xfer_done[c] = 1'b0;
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'h0, 16'h0000, "R1 cur");
        rd(4'h2, 16'h0000, "R1 ctrl");
        rd(4'h3, 16'h0000, "R1 stat");
        chk("R1 clk_en", {15'd0, dma_clk_en}, 16'd0);
        chk("R1 irq/req", {8'd0, irq, xfer_req}, 16'd0);

        // channel 0: count 3, next 5
        wr(4'h0, 16'd3);
        wr(4'h1, 16'd5);
        rd(4'h3, 16'h0001, "R4 next valid");
        wr(4'h2, 16'h0009);          // enable + tc irq enable
        tick();
        periph_req[0] = 1'b1;
        #1;
        chk("R11 req", {15'd0, xfer_req[0]}, 16'd1);
        chk("R11 narrow", {15'd0, xfer_wide[0]}, 16'd0);
        chk("R10 clk_en on", {15'd0, dma_clk_en}, 16'd1);
        dn(0, 1);
        rd(4'h0, 16'd2, "R2 decrement");
        dn(0, 2);                    // last transfer -> RELOAD
        #1;
        chk("R5 req gap", {15'd0, xfer_req[0]}, 16'd0);
        tick();
        rd(4'h0, 16'd5, "R5 reloaded");
        rd(4'h3, 16'h0000, "R5 valid cleared");

        // R6 terminal without next
        dn(0, 5);
        #1;
        chk("R6 req halted", {15'd0, xfer_req[0]}, 16'd0);
        chk("R7 irq on tc", {15'd0, irq[0]}, 16'd1);
        rd(4'h3, 16'h0002, "R6 tc set");
        dn(0, 1);
        rd(4'h3, 16'h0002, "R7 tc sticky");
        rd(4'h0, 16'd1, "R6 halted count");
        wr(4'h3, 16'h0002);
        rd(4'h3, 16'h0000, "R7 tc cleared");
        #1;
        chk("R7 irq off", {15'd0, irq[0]}, 16'd0);
        wr(4'h0, 16'd2);
        #1;
        chk("R6 resume", {15'd0, xfer_req[0]}, 16'd1);

        // R9 disable freezes
        wr(4'h2, 16'h0000);
        dn(0, 2);
        rd(4'h0, 16'd2, "R9 frozen");
        #1;
        chk("R9 no req", {15'd0, xfer_req[0]}, 16'd0);
        chk("R10 clk_en off", {15'd0, dma_clk_en}, 16'd0);

        // R8 overrun
        wr(4'h2, 16'h0011);
        wr(4'h1, 16'd7);
        wr(4'h1, 16'd8);
        rd(4'h3, 16'h0005, "R8 overrun");
        #1;
        chk("R8 irq", {15'd0, irq[0]}, 16'd1);
        wr(4'h3, 16'h0004);
        rd(4'h3, 16'h0001, "R8 cleared");
        #1;
        chk("R8 irq off", {15'd0, irq[0]}, 16'd0);

        // R3 zero means max, channel 1
        wr(4'h4, 16'd0);
        wr(4'h6, 16'h0003);          // enable + wide
        tick();
        #1;
        chk("R11 wide", {15'd0, xfer_wide[1]}, 16'd1);
        chk("R11 no req", {15'd0, xfer_req[1]}, 16'd0);
        dn(1, 1);
        rd(4'h4, 16'hFFFF, "R3 wrap");
        wr(4'h6, 16'h0007);          // add software request
        #1;
        chk("R11 sw req", {15'd0, xfer_req[1]}, 16'd1);

        // R12 window isolation
        rd(4'h8, 16'h0000, "R12 ch2 untouched");
        wr(4'h8, 16'd9);
        rd(4'h4, 16'hFFFF, "R12 ch1 kept");
        rd(4'h8, 16'd9, "R12 ch2 written");

        // R10 shared clock-enable
        wr(4'h2, 16'h0000);
        wr(4'h6, 16'h0000);
        #1;
        chk("R10 all off", {15'd0, dma_clk_en}, 16'd0);
        wr(4'hE, 16'h0001);
        #1;
        chk("R10 ch3 on", {15'd0, dma_clk_en}, 16'd1);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        summary();
    end

endmodule